// File: doc/BRIEF.md
# Conflict-Aware Rule Scheduler

This block decides, every clock cycle, which of a fixed set of guarded actions ("rules") are allowed to commit, and it steers their proposed data into a small bank of shared state registers. Each rule presents a ready flag and one candidate value per register. The block answers in the same cycle with a fire vector and per-register write enables. The register bank then loads the selected values at the next rising edge. The pairwise relations between rules are fixed at elaboration through parameters: a conflict matrix, an ordering matrix for pairs that may share a cycle, and a writer list for each register.

At elaboration, the rules are split into independent groups. A group is a connected component of the conflict graph, so rules in different groups never conflict. Each group gets its own arbiter, and that arbiter grants one ready member per cycle. A per-group parameter bit picks a fixed-priority or a rotating arbiter. Rules in different groups fire together freely. All of them read the state as it was at the start of the cycle, and their writes land together. When two fired writers of one register are ordered, the later one in the order supplies the value. Writers that are never enabled together are merged by AND-OR.

Top module: `rule_scheduler`

## Requirements
- R1: A rule's fire bit is high only while its ready bit is high.
- R2: In every group that has at least one ready rule, exactly one rule fires in that cycle.
- R3: Two rules marked as conflicting never fire in the same cycle. Rules in different groups fire in the same cycle whenever each is granted by its own group.
- R4: Groups are the connected components of the conflict graph. With the default parameters, rules 0 and 1 form one group and rules 2 and 3 form another.
- R5: A fixed-priority group grants its ready member with the lowest rule index. By default this applies to the group of rules 2 and 3, so rule 2 wins over rule 3.
- R6: A rotating group searches for a ready member starting at its pointer and moving upward through the rule indices, wrapping from N-1 to 0. The pointer moves to one past the granted index, modulo N, and only in cycles where that group grants. By default the group of rules 0 and 1 rotates.
- R7: When two fired writers of one register form an ordered pair (bit i*N+j of the ordering matrix means rule i comes before rule j), the register loads the data of the later rule j.
- R8: When a register has exactly one fired writer, or several fired writers with no ordering between them, it loads the OR of each fired writer's data ANDed with its fire bit.
- R9: A register's write enable is high exactly when at least one of its writers fires. While the enable is low, the register holds its value.
- R10: Reset is synchronous and active high. It loads each register with its slice of the initial-value parameter and sets every rotating pointer to 0. By default the registers load 8'h11 and 8'h22.
- R11: Fire bits and write enables follow the current ready inputs within the same cycle. The register outputs change only at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| can_fire | input | N_RULES | Ready flag of each rule |
| rule_data | input | N_RULES*N_REGS*DATA_W | Candidate value of rule i for register r, at bit offset (i*N_REGS+r)*DATA_W |
| will_fire | output | N_RULES | Rules that commit this cycle |
| reg_we | output | N_REGS | Write enable of each shared register |
| reg_q | output | N_REGS*DATA_W | Shared register contents; register r at bit offset r*DATA_W |

## Verification
The hardest condition to reach from the ports is the rotating group's pointer wrap. After rule 1 is granted, the pointer sits at index 2. That index is outside the group, so the search has to wrap past two non-member positions before it lands on rule 0. The second hard condition is an ordered writer pair, such as rules 0 and 3, firing together so that only the later value may land. A directed burst after reset drives all rules ready on two cycles in a row, which pushes the pointer through its wrap. It then raises exactly rules 0 and 3, and then rules 1 and 3. After that, several hundred cycles of seeded random ready and data patterns are compared against a bench model of the groups, the pointer and the ordered write rule.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int MAX_RULES = 16;
  localparam int MAX_SQ    = MAX_RULES * MAX_RULES;

  typedef enum logic {ARB_FIXED = 1'b0, ARB_ROUND = 1'b1} arb_kind_e;

  // Connected components of the conflict graph. Bit g*n+i is set when rule i
  // belongs to the group led by rule g (the lowest index in its component).
  function automatic logic [MAX_SQ-1:0] group_members(input int n,
                                                      input logic [MAX_SQ-1:0] conf);
    logic [MAX_SQ-1:0] reach;
    logic [MAX_SQ-1:0] memb;
    int lead;
    reach = '0;
    memb  = '0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        reach[i*MAX_RULES+j] = (i == j) || conf[i*n+j] || conf[j*n+i];
    for (int k = 0; k < n; k++)
      for (int i = 0; i < n; i++)
        for (int j = 0; j < n; j++)
          if (reach[i*MAX_RULES+k] && reach[k*MAX_RULES+j])
            reach[i*MAX_RULES+j] = 1'b1;
    for (int i = 0; i < n; i++) begin
      lead = i;
      for (int j = n - 1; j >= 0; j--)
        if (reach[i*MAX_RULES+j]) lead = j;
      memb[lead*n+i] = 1'b1;
    end
    return memb;
  endfunction

endpackage

// File: rtl/sched_arbiter.sv
module sched_arbiter #(
  parameter int                  N    = 4,
  parameter sched_pkg::arb_kind_e KIND = sched_pkg::ARB_FIXED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] hit_idx;
  logic             hit;

  // Search upward from the pointer with wrap; a fixed-priority instance
  // keeps its pointer parked at 0, which makes the search lowest-index-first.
  always_comb begin
    grant   = '0;
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!hit && req[idx]) begin
        hit        = 1'b1;
        grant[idx] = 1'b1;
        hit_idx    = PTR_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (KIND == sched_pkg::ARB_ROUND && hit)
      ptr_q <= (hit_idx == PTR_W'(N - 1)) ? '0 : hit_idx + 1'b1;
  end

endmodule

// File: rtl/sched_regbank.sv
module sched_regbank #(
  parameter int                 N       = 4,
  parameter int                 R       = 2,
  parameter int                 W       = 8,
  parameter logic [N*N-1:0]     SEQ     = '0,
  parameter logic [R*N-1:0]     WRITERS = '0,
  parameter logic [R*W-1:0]     INIT    = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     fire,
  input  logic [N*R*W-1:0] rule_data,
  output logic [R-1:0]     reg_we,
  output logic [R*W-1:0]   reg_q
);

  for (genvar r = 0; r < R; r++) begin : g_reg
    localparam logic [N-1:0] WMASK = WRITERS[r*N +: N];

    logic [N-1:0] sel;
    logic [W-1:0] nxt;
    logic [W-1:0] q;

    // A fired writer is dropped when a later-ordered writer also fires.
    always_comb begin
      nxt = '0;
      for (int i = 0; i < N; i++) begin
        sel[i] = fire[i] & WMASK[i] & ~(|(fire & WMASK & SEQ[i*N +: N]));
        if (sel[i]) nxt = nxt | rule_data[(i*R+r)*W +: W];
      end
    end

    assign reg_we[r] = |(fire & WMASK);

    always_ff @(posedge clk) begin
      if (rst)            q <= INIT[r*W +: W];
      else if (reg_we[r]) q <= nxt;
    end

    assign reg_q[r*W +: W] = q;
  end

endmodule

// File: rtl/rule_scheduler.sv
module rule_scheduler #(
  parameter int                            N_RULES        = 4,
  parameter int                            N_REGS         = 2,
  parameter int                            DATA_W         = 8,
  parameter logic [N_RULES*N_RULES-1:0]    CONFLICT       = 16'h4812,
  parameter logic [N_RULES*N_RULES-1:0]    SEQ_ORDER      = 16'h008C,
  parameter logic [N_REGS*N_RULES-1:0]     WRITERS        = 8'hAD,
  parameter logic [N_REGS*DATA_W-1:0]      INIT_VAL       = 16'h2211,
  parameter logic [N_RULES-1:0]            ARB_ROUND_MASK = 4'b0001
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_RULES-1:0]                can_fire,
  input  logic [N_RULES*N_REGS*DATA_W-1:0]  rule_data,
  output logic [N_RULES-1:0]                will_fire,
  output logic [N_REGS-1:0]                 reg_we,
  output logic [N_REGS*DATA_W-1:0]          reg_q
);
  localparam logic [sched_pkg::MAX_SQ-1:0] GRP_ALL =
    sched_pkg::group_members(N_RULES, sched_pkg::MAX_SQ'(CONFLICT));

  logic [N_RULES-1:0] grants [N_RULES];

  // One arbiter slot per possible group leader; empty slots never grant.
  for (genvar g = 0; g < N_RULES; g++) begin : g_grp
    localparam logic [N_RULES-1:0] MEMB = GRP_ALL[g*N_RULES +: N_RULES];
    if (ARB_ROUND_MASK[g]) begin : g_rr
      sched_arbiter #(.N(N_RULES), .KIND(sched_pkg::ARB_ROUND)) i_arb (
        .clk(clk), .rst(rst), .req(can_fire & MEMB), .grant(grants[g]));
    end else begin : g_fp
      sched_arbiter #(.N(N_RULES), .KIND(sched_pkg::ARB_FIXED)) i_arb (
        .clk(clk), .rst(rst), .req(can_fire & MEMB), .grant(grants[g]));
    end
  end

  always_comb begin
    will_fire = '0;
    for (int g = 0; g < N_RULES; g++) will_fire = will_fire | grants[g];
  end

  sched_regbank #(
    .N(N_RULES), .R(N_REGS), .W(DATA_W),
    .SEQ(SEQ_ORDER), .WRITERS(WRITERS), .INIT(INIT_VAL)
  ) i_bank (
    .clk(clk), .rst(rst), .fire(will_fire), .rule_data(rule_data),
    .reg_we(reg_we), .reg_q(reg_q)
  );

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int                         N        = 4,
  parameter int                         R        = 2,
  parameter int                         W        = 8,
  parameter logic [N*N-1:0]             CONFLICT = '0,
  parameter logic [R*W-1:0]             INIT     = '0
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   can_fire,
  input logic [N-1:0]   will_fire,
  input logic [R-1:0]   reg_we,
  input logic [R*W-1:0] reg_q
);
  logic clash;

  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j && CONFLICT[i*N+j] && will_fire[i] && will_fire[j]) clash = 1'b1;
  end

  assert_fire_needs_ready_R1: assert property (@(posedge clk) disable iff (rst)
    (will_fire & ~can_fire) == '0);

  assert_progress_R2: assert property (@(posedge clk) disable iff (rst)
    (can_fire != '0) |-> (will_fire != '0));

  assert_no_conflict_pair_R3: assert property (@(posedge clk) disable iff (rst)
    !clash);

  assert_reset_load_R10: assert property (@(posedge clk)
    rst |=> (reg_q == INIT));

  for (genvar r = 0; r < R; r++) begin : g_hold
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !reg_we[r] |=> $stable(reg_q[r*W +: W]));
  end

endmodule

bind rule_scheduler sched_checker #(
  .N(N_RULES), .R(N_REGS), .W(DATA_W), .CONFLICT(CONFLICT), .INIT(INIT_VAL)
) i_checker (
  .clk(clk), .rst(rst), .can_fire(can_fire), .will_fire(will_fire),
  .reg_we(reg_we), .reg_q(reg_q)
);

// File: tb/test_rule_scheduler.sv
module test_rule_scheduler;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int R = 2;
  localparam int W = 8;
  localparam logic [N*N-1:0] SEQ  = 16'h008C;  // 0<2, 0<3, 1<3
  localparam logic [R*N-1:0] WR   = 8'hAD;     // reg0: 0,2,3  reg1: 1,3
  localparam logic [R*W-1:0] INIT = 16'h2211;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     can_fire = '0;
  logic [N*R*W-1:0] rule_data = '0;
  logic [N-1:0]     will_fire;
  logic [R-1:0]     reg_we;
  logic [R*W-1:0]   reg_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int mptr  = 0;
  logic [R*W-1:0] mreg;

  always #(CLK_PERIOD/2) clk = ~clk;

  rule_scheduler i_rule_scheduler (
    .clk(clk), .rst(rst), .can_fire(can_fire), .rule_data(rule_data),
    .will_fire(will_fire), .reg_we(reg_we), .reg_q(reg_q));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Groups {0,1} rotating and {2,3} fixed priority (R4, R5, R6)
  function automatic logic [N-1:0] exp_fire(input logic [N-1:0] cf, input int ptr);
    logic [N-1:0] f = '0;
    bit got = 0;
    for (int k = 0; k < N; k++) begin
      int idx = (ptr + k) % N;
      if (!got && idx < 2 && cf[idx]) begin f[idx] = 1'b1; got = 1; end
    end
    if (cf[2]) f[2] = 1'b1;
    else if (cf[3]) f[3] = 1'b1;
    return f;
  endfunction

  // Sequential application in index order: ordered successor overwrites (R7), else OR (R8)
  function automatic logic [W-1:0] exp_reg(input int r, input logic [N-1:0] f,
                                           input logic [N*R*W-1:0] d, input logic [W-1:0] old);
    logic [W-1:0] acc = '0;
    int last = -1;
    for (int i = 0; i < N; i++) begin
      if (f[i] && WR[r*N+i]) begin
        if (last >= 0 && SEQ[last*N+i]) acc = d[(i*R+r)*W +: W];
        else acc = acc | d[(i*R+r)*W +: W];
        last = i;
      end
    end
    return (last >= 0) ? acc : old;
  endfunction

  task automatic step(input logic [N-1:0] cf, input logic [N*R*W-1:0] d);
    logic [N-1:0]   ef;
    logic [R-1:0]   ewe;
    logic [R*W-1:0] enext;
    @(negedge clk);
    can_fire  = cf;
    rule_data = d;
    #1;
    ef = exp_fire(cf, mptr);
    check("R1 R2 R3 R5 R6 will_fire", {60'd0, will_fire}, {60'd0, ef});
    for (int r = 0; r < R; r++) begin
      ewe[r] = |(ef & WR[r*N +: N]);
      enext[r*W +: W] = exp_reg(r, ef, d, mreg[r*W +: W]);
    end
    check("R9 reg_we", {62'd0, reg_we}, {62'd0, ewe});
    check("R11 reg_q before edge", {48'd0, reg_q}, {48'd0, mreg});
    @(posedge clk);
    #1;
    mreg = enext;
    for (int k = 0; k < 2; k++)
      if (ef[k]) mptr = (k + 1) % N;
    check("R7 R8 R9 reg_q after edge", {48'd0, reg_q}, {48'd0, mreg});
  endtask

  function automatic logic [N*R*W-1:0] rnd_data();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      done = 1'b1;
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    mreg = INIT;
    check("R10 reset value", {48'd0, reg_q}, {48'd0, INIT});
    // R10 pointer at 0: rule 0 wins first; R3 R4 rules 0 and 2 fire together
    step(4'b1111, 64'h0102030405060708);
    step(4'b1111, 64'h1112131415161718);   // R6 rotation to rule 1
    step(4'b0000, 64'hFFFFFFFFFFFFFFFF);   // R9 hold
    step(4'b1001, 64'hA1A2A3A4A5A6A7A8);   // R6 wrap to rule 0, R7 rule 3 wins
    step(4'b1010, 64'hB1B2B3B4B5B6B7B8);   // R7 pair 1<3
    step(4'b1000, 64'hC1C2C3C4C5C6C7C8);   // R5 rule 3 alone
    step(4'b0100, 64'hD1D2D3D4D5D6D7D8);   // R8 single writer
    for (int n = 0; n < 400; n++) step(4'($urandom), rnd_data());
    // R10 reset mid-run restores values and pointer
    @(negedge clk);
    can_fire = '0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    mreg = INIT;
    mptr = 0;
    check("R10 reset again", {48'd0, reg_q}, {48'd0, INIT});
    step(4'b0011, 64'h5555AAAA5555AAAA);
    for (int n = 0; n < 100; n++) step(4'($urandom), rnd_data());
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule